// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a host reach the management registers of Ethernet PHYs over the two-wire serial management bus. The host programs it through five 64-bit registers on a simple write/read port: an enable, a clock and framing configuration, a payload for outgoing data, and a command. A command write starts one serial frame. The block generates the management clock, drives the data line through an output enable, and captures the data the PHY returns during read frames.

One configuration bit selects the framing family. It also changes how the 2-bit command opcode is mapped onto the wire: the same opcode value means a different operation under Clause 22 and under Clause 45. Progress and results are reported through a pending flag and a valid flag in each of the two data registers. The host starts a command, polls pending until it drops, and then looks at valid and, for reads, at the 16 captured bits.

Top module: `mdio_master`

## Requirements
- R1: Register offsets are command 0x00, payload 0x08, read result 0x10, configuration 0x18, enable 0x20. After reset every register reads zero. Bits with no field, and any other offset, read as zero. The configuration fields read back from the positions they were written to: phase count 7:0, sample point 11:8, preamble 12, idle level 13, sample mode 15, extended sample 20:16, Clause 45 select 24.
- R2: While enable bit 0 is clear, a command write starts no frame and leaves the command register unchanged, MDC rests at the configured idle level and MDIO is not driven.
- R3: During a frame, MDC is low for max(phase,1) system clocks and then high for max(phase,1) clocks, so one bit lasts 2*max(phase,1) clocks. MDIO changes only while MDC is low.
- R4: With configuration bit 12 set, a frame opens with 32 ones. With bit 12 clear, the frame has no preamble.
- R5: In Clause 22 mode (bit 24 = 0), the frame after the preamble is start 01, then the wire opcode (01 for command opcode 0, a write; 10 for command opcode 1, a read), then the PHY address from command bits 12:8, then the register address from bits 4:0, all sent MSB first.
- R6: In Clause 45 mode (bit 24 = 1), the start code is 00. Command opcode 0 sends the address operation 00, opcode 1 sends the write 01 and opcode 3 sends the read 11. The device address comes from command bits 4:0.
- R7: For writes and address operations, the turnaround is driven as 10 and is followed by the 16 payload bits, MSB first. The payload is bits 15:0 of the payload register at the moment the command is accepted.
- R8: For reads, MDIO is released during the turnaround and the 16 data bits, and MDIO is sampled on each MDC rise. At the end, bits 15:0 of the read result register hold the sampled bits, and its bit 16 (valid) is set only if the PHY drove the second turnaround bit low.
- R9: When a command is accepted, bit 17 (pending) of the read result register is set for a read, or of the payload register for any other operation, and bit 16 of the same register is cleared. At the end of the frame pending clears. After a non-read frame, bit 16 of the payload register is set.
- R10: A command write while either pending flag is set starts nothing and leaves the command register unchanged.
- R11: An opcode with no meaning in the current mode (2 or 3 in Clause 22, 2 in Clause 45) is ignored: no frame starts and the command register is unchanged.
- R12: Between frames, MDC sits at the idle level from configuration bit 13 and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |

## Verification
The assertions assume that the host issues at most one register write per cycle and that MDC is observed only through the block's own outputs. They also assume that the configuration is not rewritten while a frame is pending, since the check that MDIO stays stable while MDC is high depends on a fixed phase count. The bench keeps to these assumptions. It waits for pending to drop before it writes a new configuration, and it writes to the command register during a frame only in the dedicated overlap test. A behavioural PHY model answers reads by changing MDIO right after each MDC rise, so every sampled bit is already stable a full half period before it is captured.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned HDR_LEN   = 14;  // start + opcode + phy + reg
  localparam int unsigned TA_LEN    = 2;
  localparam int unsigned DAT_LEN   = 16;
  localparam int unsigned FRAME_LEN = HDR_LEN + TA_LEN + DAT_LEN;

  localparam logic [5:0] OFS_CMD  = 6'h00;
  localparam logic [5:0] OFS_WDAT = 6'h08;
  localparam logic [5:0] OFS_RDAT = 6'h10;
  localparam logic [5:0] OFS_CFG  = 6'h18;
  localparam logic [5:0] OFS_EN   = 6'h20;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] dev;
  } cmd_t;

  typedef struct packed {
    logic       c45;
    logic [4:0] smp_ext;
    logic       smp_mode;
    logic       idle;
    logic       pre;
    logic [3:0] smp;
    logic [7:0] phase;
  } cfg_t;

  typedef struct packed {
    logic       legal;
    logic       rd;
    logic [1:0] wop;
  } opdec_t;

  function automatic opdec_t op_decode(input logic c45, input logic [1:0] op);
    opdec_t d;
    d = '0;
    if (!c45) begin
      case (op)
        2'd0: d = '{legal: 1'b1, rd: 1'b0, wop: 2'b01};
        2'd1: d = '{legal: 1'b1, rd: 1'b1, wop: 2'b10};
        default: d = '0;
      endcase
    end else begin
      case (op)
        2'd0: d = '{legal: 1'b1, rd: 1'b0, wop: 2'b00};
        2'd1: d = '{legal: 1'b1, rd: 1'b0, wop: 2'b01};
        2'd3: d = '{legal: 1'b1, rd: 1'b1, wop: 2'b11};
        default: d = '0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               idle_lvl_i,
  output logic               mdc_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [PHASE_W-1:0] cnt_q, lim;
  logic               hi_q, wrap;

  always_comb begin
    lim  = (phase_i == '0) ? PHASE_W'(1) : phase_i;
    wrap = (cnt_q >= lim - PHASE_W'(1));
  end

  assign rise_o = run_i && wrap && !hi_q;
  assign fall_o = run_i && wrap && hi_q;
  assign mdc_o  = run_i ? hi_q : idle_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      hi_q  <= ~hi_q;
    end else begin
      cnt_q <= cnt_q + PHASE_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_master_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               c45_i,
  input  logic               rd_i,
  input  logic [1:0]         wop_i,
  input  logic [4:0]         phy_i,
  input  logic [4:0]         dev_i,
  input  logic [DAT_LEN-1:0] payload_i,
  input  logic               pre_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DAT_LEN-1:0] rd_data_o,
  output logic               rd_ok_o
);
  localparam int CNT_W = $clog2(PRE_LEN + FRAME_LEN + 1);

  logic                 busy_q, rd_q, ta_low_q;
  logic [CNT_W-1:0]     idx_q, pre_len_q, last, pos;
  logic [FRAME_LEN-1:0] fw_q;
  logic [DAT_LEN-1:0]   rsh_q;
  logic                 in_body, released;

  always_comb begin
    last     = pre_len_q + CNT_W'(FRAME_LEN - 1);
    in_body  = (idx_q >= pre_len_q);
    pos      = idx_q - pre_len_q;
    released = rd_q && in_body && (pos >= CNT_W'(HDR_LEN));
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && (idx_q == last) && !abort_i;
  assign mdio_o    = (!busy_q || !in_body) ? 1'b1 : fw_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && !released;
  assign rd_data_o = rsh_q;
  assign rd_ok_o   = ta_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_q      <= 1'b0;
      ta_low_q  <= 1'b0;
      idx_q     <= '0;
      pre_len_q <= '0;
      fw_q      <= '0;
      rsh_q     <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q    <= 1'b1;
      rd_q      <= rd_i;
      ta_low_q  <= 1'b0;
      idx_q     <= '0;
      rsh_q     <= '0;
      pre_len_q <= pre_i ? CNT_W'(PRE_LEN) : '0;
      fw_q      <= {(c45_i ? 2'b00 : 2'b01), wop_i, phy_i, dev_i,
                    (rd_i ? 2'b11 : 2'b10),
                    (rd_i ? {DAT_LEN{1'b1}} : payload_i)};
    end else if (busy_q) begin
      if (rise_i) begin
        if (rd_q && in_body && pos == CNT_W'(HDR_LEN + 1))
          ta_low_q <= ~mdio_i;
        if (rd_q && in_body && pos >= CNT_W'(HDR_LEN + TA_LEN))
          rsh_q <= {rsh_q[DAT_LEN-2:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == last) busy_q <= 1'b0;
        else               idx_q  <= idx_q + CNT_W'(1);
        if (in_body) fw_q <= {fw_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               done_i,
  input  logic [DAT_LEN-1:0] rd_data_i,
  input  logic               rd_ok_i,
  output logic               start_o,
  output logic               c45_o,
  output logic               rd_o,
  output logic [1:0]         wop_o,
  output logic [4:0]         phy_o,
  output logic [4:0]         dev_o,
  output logic [DAT_LEN-1:0] payload_o,
  output logic               pre_o,
  output logic [7:0]         phase_o,
  output logic               idle_o,
  output logic               en_o,
  output logic               pend_rd_o,
  output logic               pend_wr_o
);
  cmd_t               cmd_q, cmd_new;
  cfg_t               cfg_q;
  opdec_t             dec;
  logic [DAT_LEN-1:0] wdat_q, rdat_q;
  logic               en_q, pend_rd_q, pend_wr_q, val_rd_q, val_wr_q;
  logic               hit_cmd, launch;
  logic               unused_bits;

  assign unused_bits = ^{wdata_i[DATA_W-1:25], wdata_i[23:21], wdata_i[14],
                         wdata_i[7:5], wdata_i[15:13]};

  always_comb begin
    cmd_new = '{op: wdata_i[17:16], phy: wdata_i[12:8], dev: wdata_i[4:0]};
    dec     = op_decode(cfg_q.c45, cmd_new.op);
    hit_cmd = we_i && (addr_i == ADDR_W'(OFS_CMD));
    launch  = hit_cmd && en_q && !pend_rd_q && !pend_wr_q && dec.legal;
  end

  assign start_o   = launch;
  assign c45_o     = cfg_q.c45;
  assign rd_o      = dec.rd;
  assign wop_o     = dec.wop;
  assign phy_o     = cmd_new.phy;
  assign dev_o     = cmd_new.dev;
  assign payload_o = wdat_q;
  assign pre_o     = cfg_q.pre;
  assign phase_o   = cfg_q.phase;
  assign idle_o    = cfg_q.idle;
  assign en_o      = en_q;
  assign pend_rd_o = pend_rd_q;
  assign pend_wr_o = pend_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cfg_q     <= '0;
      wdat_q    <= '0;
      rdat_q    <= '0;
      en_q      <= 1'b0;
      pend_rd_q <= 1'b0;
      pend_wr_q <= 1'b0;
      val_rd_q  <= 1'b0;
      val_wr_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_W'(OFS_WDAT)) wdat_q <= wdata_i[DAT_LEN-1:0];
      if (we_i && addr_i == ADDR_W'(OFS_EN))   en_q   <= wdata_i[0];
      if (we_i && addr_i == ADDR_W'(OFS_CFG)) begin
        cfg_q.phase    <= wdata_i[7:0];
        cfg_q.smp      <= wdata_i[11:8];
        cfg_q.pre      <= wdata_i[12];
        cfg_q.idle     <= wdata_i[13];
        cfg_q.smp_mode <= wdata_i[15];
        cfg_q.smp_ext  <= wdata_i[20:16];
        cfg_q.c45      <= wdata_i[24];
      end
      if (launch) begin
        cmd_q <= cmd_new;
        if (dec.rd) begin
          pend_rd_q <= 1'b1;
          val_rd_q  <= 1'b0;
        end else begin
          pend_wr_q <= 1'b1;
          val_wr_q  <= 1'b0;
        end
      end
      if (done_i) begin
        if (pend_rd_q) begin
          rdat_q   <= rd_data_i;
          val_rd_q <= rd_ok_i;
        end
        if (pend_wr_q) val_wr_q <= 1'b1;
        pend_rd_q <= 1'b0;
        pend_wr_q <= 1'b0;
      end
      if (!en_q) begin
        pend_rd_q <= 1'b0;
        pend_wr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CMD): begin
        rdata_o[17:16] = cmd_q.op;
        rdata_o[12:8]  = cmd_q.phy;
        rdata_o[4:0]   = cmd_q.dev;
      end
      ADDR_W'(OFS_WDAT): begin
        rdata_o[17]           = pend_wr_q;
        rdata_o[16]           = val_wr_q;
        rdata_o[DAT_LEN-1:0]  = wdat_q;
      end
      ADDR_W'(OFS_RDAT): begin
        rdata_o[17]           = pend_rd_q;
        rdata_o[16]           = val_rd_q;
        rdata_o[DAT_LEN-1:0]  = rdat_q;
      end
      ADDR_W'(OFS_CFG): begin
        rdata_o[7:0]   = cfg_q.phase;
        rdata_o[11:8]  = cfg_q.smp;
        rdata_o[12]    = cfg_q.pre;
        rdata_o[13]    = cfg_q.idle;
        rdata_o[15]    = cfg_q.smp_mode;
        rdata_o[20:16] = cfg_q.smp_ext;
        rdata_o[24]    = cfg_q.c45;
      end
      ADDR_W'(OFS_EN): rdata_o[0] = en_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int PHASE_W = 8;

  logic               start_w, c45_w, rd_w, pre_w, idle_w, en_w;
  logic               pend_rd_w, pend_wr_w;
  logic [1:0]         wop_w;
  logic [4:0]         phy_w, dev_w;
  logic [DAT_LEN-1:0] payload_w, rd_data_w;
  logic [PHASE_W-1:0] phase_w;
  logic               busy_w, done_w, rd_ok_w, rise_w, fall_w;

  mdio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .done_i    (done_w),
    .rd_data_i (rd_data_w),
    .rd_ok_i   (rd_ok_w),
    .start_o   (start_w),
    .c45_o     (c45_w),
    .rd_o      (rd_w),
    .wop_o     (wop_w),
    .phy_o     (phy_w),
    .dev_o     (dev_w),
    .payload_o (payload_w),
    .pre_o     (pre_w),
    .phase_o   (phase_w),
    .idle_o    (idle_w),
    .en_o      (en_w),
    .pend_rd_o (pend_rd_w),
    .pend_wr_o (pend_wr_w)
  );

  mdio_clkgen #(.PHASE_W(PHASE_W)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy_w),
    .phase_i    (phase_w),
    .idle_lvl_i (idle_w),
    .mdc_o      (mdc_o),
    .rise_o     (rise_w),
    .fall_o     (fall_w)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .abort_i   (!en_w),
    .c45_i     (c45_w),
    .rd_i      (rd_w),
    .wop_i     (wop_w),
    .phy_i     (phy_w),
    .dev_i     (dev_w),
    .payload_i (payload_w),
    .pre_i     (pre_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .mdio_i    (mdio_i),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data_w),
    .rd_ok_o   (rd_ok_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              en_q,
  input logic              idle_q,
  input logic              pend_rd,
  input logic              pend_wr,
  input logic              val_rd,
  input logic [11:0]       cmd_q
);
  logic pend_any;
  assign pend_any = pend_rd || pend_wr;

  // R2
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !$past(en_q)) |-> (mdc_o == idle_q && !mdio_oe_o));

  // R9
  pend_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pend_rd, pend_wr}));

  // R10
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_any && bus_we_i && bus_addr_i == '0) |=> $stable(cmd_q));

  // R8
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(val_rd) |-> $fell(pend_rd));

  // R3
  mdio_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_any && $past(pend_any) && mdc_o && $past(mdc_o)) |-> $stable(mdio_o));

  // R12
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_any |-> !mdio_oe_o);
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .en_q       (en_w),
  .idle_q     (idle_w),
  .pend_rd    (pend_rd_w),
  .pend_wr    (pend_wr_w),
  .val_rd     (u_regs.val_rd_q),
  .cmd_q      (u_regs.cmd_q)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 64;
  localparam int CMD = 'h00, WDAT = 'h08, RDAT = 'h10, CFG = 'h18, EN = 'h20;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              mdc, mdio_in, mdio_out, mdio_oe;

  int checks = 0, fails = 0;
  int cyc = 0;
  int nr = 0;
  int base = 0;
  bit done = 1'b0;
  logic [63:0] resp;
  logic        cap_d  [0:4095];
  logic        cap_oe [0:4095];
  int          cap_t  [0:4095];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: presents bit k of resp until the k-th MDC rise has passed
  assign mdio_in = resp[(nr - base) & 63];
  always @(posedge mdc) begin
    cap_d[nr & 4095]  = mdio_out;
    cap_oe[nr & 4095] = mdio_oe;
    cap_t[nr & 4095]  = cyc;
    nr = nr + 1;
  end

  mdio_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe));

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(int a, longint d);
    @(negedge clk);
    we = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic br(int a, output longint d);
    addr = ADDR_W'(a);
    #1;
    d = longint'(rdata);
  endtask

  task automatic wait_idle(int reg_ofs);
    longint v;
    for (int i = 0; i < 40000; i++) begin
      br(reg_ofs, v);
      if (v[17] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  function automatic int wire_op(int c45, int op);
    if (c45 == 0) return (op == 0) ? 1 : 2;
    return (op == 0) ? 0 : ((op == 1) ? 1 : 3);
  endfunction

  task automatic run_frame(int c45, int op, int phy, int dev, int pay,
                           int pre, int phase, int idle, int answer, int rdv);
    longint v;
    int lim, rd, pl, n, e_pre, e_hdr, e_tail, e_oe, exp_b, k;
    logic [31:0] fw;
    string hdr_tag;
    rd  = (c45 == 0) ? (op == 1) : (op == 3);
    lim = (phase == 0) ? 1 : phase;
    pl  = pre ? 32 : 0;
    n   = pl + 32;
    hdr_tag = c45 ? "R6" : "R5";
    resp = '1;
    if (rd) begin
      resp[pl + 15] = answer ? 1'b0 : 1'b1;
      for (int i = 0; i < 16; i++) resp[pl + 16 + i] = rdv[15 - i];
    end
    bw(CFG, phase | (pre << 12) | (idle << 13) | (c45 << 24));
    bw(WDAT, pay);
    base = nr;
    bw(CMD, (op << 16) | (phy << 8) | dev);
    br(rd ? RDAT : WDAT, v);
    chk("R9 pending set", v[17], 1);
    chk("R9 valid cleared", v[16], 0);
    wait_idle(rd ? RDAT : WDAT);
    chk("R12 idle mdc", mdc, idle);
    chk("R12 idle oe", mdio_oe, 0);
    chk("R4 bit count", nr - base, n);
    chk("R3 bit period", cap_t[(base + 1) & 4095] - cap_t[base & 4095], 2 * lim);
    fw = {(c45 ? 2'b00 : 2'b01), 2'(wire_op(c45, op)), 5'(phy), 5'(dev), 2'b10, 16'(pay)};
    e_pre = 0; e_hdr = 0; e_tail = 0; e_oe = 0;
    for (int i = 0; i < n; i++) begin
      k = (base + i) & 4095;
      if (i < pl) begin
        if (cap_d[k] !== 1'b1 || cap_oe[k] !== 1'b1) e_pre++;
      end else if (i - pl < 14) begin
        exp_b = fw[31 - (i - pl)];
        if (cap_d[k] !== 1'(exp_b) || cap_oe[k] !== 1'b1) e_hdr++;
      end else if (rd) begin
        if (cap_oe[k] !== 1'b0) e_oe++;
      end else begin
        exp_b = fw[31 - (i - pl)];
        if (cap_d[k] !== 1'(exp_b) || cap_oe[k] !== 1'b1) e_tail++;
      end
    end
    chk("R4 preamble bits", e_pre, 0);
    chk({hdr_tag, " header bits"}, e_hdr, 0);
    if (rd) begin
      chk("R8 released bits", e_oe, 0);
      br(RDAT, v);
      chk("R8 read data", v[15:0], rdv & 'hffff);
      chk("R8 valid", v[16], answer);
    end else begin
      chk("R7 turnaround and payload", e_tail, 0);
      br(WDAT, v);
      chk("R9 write valid", v[16], 1);
    end
  endtask

  initial begin
    longint v;
    int ops[2][3];
    int nops;
    ops[0][0] = 0; ops[0][1] = 1;
    ops[1][0] = 0; ops[1][1] = 1; ops[1][2] = 3;
    resp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 'h28; a += 8) begin
      br(a, v);
      chk("R1 reset value", v, 0);
    end
    chk("R12 reset mdc", mdc, 0);
    chk("R12 reset oe", mdio_oe, 0);
    // R1 readback masks
    bw(CFG, -1);
    br(CFG, v);
    chk("R1 config fields", v, 'h011FBFFF);
    bw(EN, -1);
    br(EN, v);
    chk("R1 enable field", v, 1);
    bw(WDAT, 'h3_ABCD);
    br(WDAT, v);
    chk("R1 payload field", v, 'hABCD);
    br('h28, v);
    chk("R1 unmapped offset", v, 0);
    bw(CFG, 0);
    // R2 disabled
    bw(EN, 0);
    for (int idl = 0; idl < 2; idl++) begin
      bw(CFG, 1 | (idl << 13));
      base = nr;
      bw(CMD, (1 << 8) | 2);
      repeat (40) @(negedge clk);
      chk("R2 no frame when disabled", nr - base, 0);
      chk("R2 mdc idle when disabled", mdc, idl);
      br(CMD, v);
      chk("R2 command unchanged", v, 0);
    end
    bw(EN, 1);
    // sweep over modes, opcodes, phase, preamble, idle level
    for (int m = 0; m < 2; m++) begin
      nops = m ? 3 : 2;
      for (int oi = 0; oi < nops; oi++)
        for (int ph = 0; ph < 4; ph++)
          for (int pr = 0; pr < 2; pr++)
            run_frame(m, ops[m][oi], (ph * 7 + oi * 3 + m) & 31,
                      (ph * 5 + pr * 11 + oi) & 31,
                      (16'hA5C3 ^ (ph << 9) ^ (oi << 4) ^ m) & 'hffff,
                      pr, ph, (ph + pr) & 1, (ph != 2), 'h1234 + ph * 'h1111 + m);
    end
    // R10 command while pending
    bw(CFG, 3 | (1 << 12));
    bw(WDAT, 'h5555);
    base = nr;
    bw(CMD, (5 << 8) | 9);
    bw(CMD, (1 << 16) | (1 << 8) | 2);
    br(CMD, v);
    chk("R10 command kept", v, (5 << 8) | 9);
    br(RDAT, v);
    chk("R10 no read pending", v[17], 0);
    wait_idle(WDAT);
    chk("R10 single frame", nr - base, 64);
    // R11 illegal opcodes
    for (int m = 0; m < 2; m++)
      for (int op = 2; op < 4; op++)
        if (!(m == 1 && op == 3)) begin
          bw(CFG, 1 | (m << 24));
          base = nr;
          bw(CMD, (op << 16) | (7 << 8) | 7);
          br(WDAT, v);
          chk("R11 no write pending", v[17], 0);
          br(RDAT, v);
          chk("R11 no read pending", v[17], 0);
          repeat (20) @(negedge clk);
          chk("R11 no frame", nr - base, 0);
          br(CMD, v);
          chk("R11 command unchanged", v, (5 << 8) | 9);
        end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule